// File: doc/BRIEF.md
# Dual-Port RAM with Busy Arbitration

This block is a synchronous true dual-port memory with a left and a right port. Each port has its own address, active-low chip enable, read/write strobe, write data and registered read data, so the two sides run independently and neither ever waits on the other. The depth is 2**ADDR_W words of DATA_W bits. The default is a 1K x 8 array so that the block elaborates quickly. Setting ADDR_W to 13 gives the 8K x 8 configuration.

When both enabled ports present the same address in the same cycle, an arbiter lets one side proceed. The other side is the loser. The loser sees its active-low busy output fall one clock later, and any write it attempts is suppressed inside the block in that same cycle. Reads on the losing side still complete.

A mode input selects how busy behaves. In master mode, busy is driven out as the arbitration result. In slave mode, the busy outputs stay high and each port's busy input works only as a write inhibit. Wide arrays use this mode: several slaves follow the busy decision of a single master.

Top module: `dpram_busy_arb`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits. A write on one port can be read on the other port in the very next cycle. In master mode, two writes to different addresses in the same cycle both take effect.
- R2: A port with ce_n low and rw_n high (read) updates its rdata on the next clock edge. The value is the word stored before any write of that same cycle. In every other cycle, rdata holds its value.
- R3: A collision occurs when both ce_n inputs are low and the two addresses are equal. The decision uses only the enables and the addresses, so two reads collide exactly as writes do. In master mode, the losing port's busy_out_n is low in the cycle after the collision and high again in the cycle after the collision ends. The two busy outputs are never low together.
- R4: If a collision starts with neither port holding the address from the previous cycle, the left port wins.
- R5: A port "holds" the address when it was enabled at that same address in the previous cycle. If it holds the address and the other port does not, it wins the collision. An ongoing collision keeps its winner for as long as both addresses stay unchanged.
- R6: In master mode, a write from the losing port (rw_n low) leaves the memory unchanged in that cycle. A read from the losing port returns the stored word.
- R7: In slave mode, both busy_out_n outputs are high one cycle after the mode is selected. In slave mode, a port whose busy_in_n is low cannot write, and busy_in_n high allows the write. In master mode, busy_in_n has no effect.
- R8: A port with ce_n high is in standby. It writes nothing, and its rdata holds its value.
- R9: After synchronous reset (rst high), both busy_out_n outputs are high and both rdata outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| master_mode | input | 1 | 1 = busy is an arbitration output, 0 = busy is a write-inhibit input |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_rw_n | input | 1 | Left strobe: 1 = read, 0 = write |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_busy_in_n | input | 1 | Left write inhibit in slave mode, active low |
| l_rdata | output | DATA_W | Left registered read data |
| l_busy_out_n | output | 1 | Left busy flag in master mode, active low, registered |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw_n | input | 1 | Right strobe: 1 = read, 0 = write |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_busy_in_n | input | 1 | Right write inhibit in slave mode, active low |
| r_rdata | output | DATA_W | Right registered read data |
| r_busy_out_n | output | 1 | Right busy flag in master mode, active low, registered |

## Verification
The assertions assume that all inputs are stable between the rising edges they are sampled on, and that reset is held for at least one edge before traffic begins. They also assume that the mode input changes only at cycle boundaries. The check against two same-address writes relies on master mode alone, because in slave mode the arbitration is delegated to an outside master. The stimulus therefore drives every input half a period away from the active edge and switches modes only in whole blocks of cycles. It confines random addresses to a handful of pre-written words, so that collisions, grant hand-overs and reads of known data come up often.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

   // Which port currently owns a contested address
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_e;

   localparam int NUM_PORTS = 2;
   localparam int PORT_L    = 0;
   localparam int PORT_R    = 1;

endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
   import dpram_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              master,
   input  logic              en_l,
   input  logic              en_r,
   input  logic [ADDR_W-1:0] addr_l,
   input  logic [ADDR_W-1:0] addr_r,
   output logic              lose_l,
   output logic              lose_r,
   output logic              busy_l_n,
   output logic              busy_r_n
);

   logic              pen_l, pen_r;
   logic [ADDR_W-1:0] paddr_l, paddr_r;
   owner_e            owner_q, winner, owner_d;
   logic              coll, hold_l, hold_r, cont;

   assign coll   = en_l && en_r && (addr_l == addr_r);
   assign hold_l = pen_l && (paddr_l == addr_l);
   assign hold_r = pen_r && (paddr_r == addr_r);
   assign cont   = (owner_q != OWN_NONE) && hold_l && hold_r;

   always_comb begin
      if (cont)
         winner = owner_q;
      else if (hold_r && !hold_l)
         winner = OWN_RIGHT;
      else
         winner = OWN_LEFT;
      owner_d = coll ? winner : OWN_NONE;
   end

   assign lose_l = coll && (winner == OWN_RIGHT);
   assign lose_r = coll && (winner == OWN_LEFT);

   always_ff @(posedge clk) begin
      if (rst) begin
         pen_l    <= 1'b0;
         pen_r    <= 1'b0;
         paddr_l  <= '0;
         paddr_r  <= '0;
         owner_q  <= OWN_NONE;
         busy_l_n <= 1'b1;
         busy_r_n <= 1'b1;
      end else begin
         pen_l    <= en_l;
         pen_r    <= en_r;
         paddr_l  <= addr_l;
         paddr_r  <= addr_r;
         owner_q  <= owner_d;
         busy_l_n <= !(master && lose_l);
         busy_r_n <= !(master && lose_r);
      end
   end

   // R3
   one_loser_chk: assert property (@(posedge clk) disable iff (rst)
      !(lose_l && lose_r));

   // R3
   busy_pair_chk: assert property (@(posedge clk) disable iff (rst)
      busy_l_n || busy_r_n);

   // R5
   grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (coll && $past(coll) && $stable(addr_l) && $stable(addr_r))
      |-> ($stable(lose_l) && $stable(lose_r)));

endmodule

// File: rtl/dpram_wgate.sv
module dpram_wgate (
   input  logic en,
   input  logic wr,
   input  logic master,
   input  logic lose,
   input  logic inhibit_n,
   output logic wen
);

   logic permit;

   // Master: own arbitration result; slave: external inhibit pin
   assign permit = master ? !lose : inhibit_n;
   assign wen    = en && wr && permit;

endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [1:0]                   wen,
   input  logic [1:0]                   ren,
   input  logic [1:0][ADDR_W-1:0]       addr,
   input  logic [1:0][DATA_W-1:0]       wdata,
   output logic [1:0][DATA_W-1:0]       rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // Right written first so that left has the last word in slave mode
   always_ff @(posedge clk) begin
      if (wen[1]) mem[addr[1]] <= wdata[1];
      if (wen[0]) mem[addr[0]] <= wdata[0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata <= '0;
      end else begin
         for (int p = 0; p < 2; p++) begin
            if (ren[p]) rdata[p] <= mem[addr[p]];
         end
      end
   end

endmodule

// File: rtl/dpram_busy_arb.sv
module dpram_busy_arb
   import dpram_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              master_mode,
   input  logic              l_ce_n,
   input  logic              l_rw_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   input  logic              l_busy_in_n,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_busy_out_n,
   input  logic              r_ce_n,
   input  logic              r_rw_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   input  logic              r_busy_in_n,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_busy_out_n
);

   if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_addr_w
      $error("dpram_busy_arb: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("dpram_busy_arb: DATA_W must be positive");
   end

   logic [NUM_PORTS-1:0]             en, wr, inh_n, lose, wen, ren;
   logic [NUM_PORTS-1:0][ADDR_W-1:0] addr;
   logic [NUM_PORTS-1:0][DATA_W-1:0] wdata, rdata;

   assign en[PORT_L]    = !l_ce_n;
   assign en[PORT_R]    = !r_ce_n;
   assign wr[PORT_L]    = !l_rw_n;
   assign wr[PORT_R]    = !r_rw_n;
   assign inh_n[PORT_L] = l_busy_in_n;
   assign inh_n[PORT_R] = r_busy_in_n;
   assign addr[PORT_L]  = l_addr;
   assign addr[PORT_R]  = r_addr;
   assign wdata[PORT_L] = l_wdata;
   assign wdata[PORT_R] = r_wdata;

   dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
      .clk      (clk),
      .rst      (rst),
      .master   (master_mode),
      .en_l     (en[PORT_L]),
      .en_r     (en[PORT_R]),
      .addr_l   (addr[PORT_L]),
      .addr_r   (addr[PORT_R]),
      .lose_l   (lose[PORT_L]),
      .lose_r   (lose[PORT_R]),
      .busy_l_n (l_busy_out_n),
      .busy_r_n (r_busy_out_n)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      dpram_wgate u_gate (
         .en        (en[p]),
         .wr        (wr[p]),
         .master    (master_mode),
         .lose      (lose[p]),
         .inhibit_n (inh_n[p]),
         .wen       (wen[p])
      );
      assign ren[p] = en[p] && !wr[p];
   end

   dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .rst   (rst),
      .wen   (wen),
      .ren   (ren),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata)
   );

   assign l_rdata = rdata[PORT_L];
   assign r_rdata = rdata[PORT_R];

   // R6
   no_dual_write_chk: assert property (@(posedge clk) disable iff (rst)
      master_mode |-> !(wen[PORT_L] && wen[PORT_R] && (l_addr == r_addr)));

   // R7
   slave_busy_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(master_mode) |-> (l_busy_out_n && r_busy_out_n));

endmodule

// File: tb/sim_dpram_busy_arb.sv
module sim_dpram_busy_arb;

   localparam int CLK_P = 10;
   localparam int AW    = 10;
   localparam int DW    = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          master_mode = 1'b1;
   logic          l_ce_n = 1'b1, l_rw_n = 1'b1, l_busy_in_n = 1'b1;
   logic [AW-1:0] l_addr = '0;
   logic [DW-1:0] l_wdata = '0;
   logic [DW-1:0] l_rdata;
   logic          l_busy_out_n;
   logic          r_ce_n = 1'b1, r_rw_n = 1'b1, r_busy_in_n = 1'b1;
   logic [AW-1:0] r_addr = '0;
   logic [DW-1:0] r_wdata = '0;
   logic [DW-1:0] r_rdata;
   logic          r_busy_out_n;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   // bench model state
   logic [DW-1:0] mem [1 << AW];
   logic          m_pen_l = 1'b0, m_pen_r = 1'b0;
   logic [AW-1:0] m_pa_l = '0, m_pa_r = '0;
   int            m_owner = 0;
   logic [DW-1:0] e_rd_l = '0, e_rd_r = '0;
   logic          e_bl = 1'b1, e_br = 1'b1;

   always #(CLK_P/2) clk = ~clk;

   dpram_busy_arb #(.ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk(clk), .rst(rst), .master_mode(master_mode),
      .l_ce_n(l_ce_n), .l_rw_n(l_rw_n), .l_addr(l_addr), .l_wdata(l_wdata),
      .l_busy_in_n(l_busy_in_n), .l_rdata(l_rdata), .l_busy_out_n(l_busy_out_n),
      .r_ce_n(r_ce_n), .r_rw_n(r_rw_n), .r_addr(r_addr), .r_wdata(r_wdata),
      .r_busy_in_n(r_busy_in_n), .r_rdata(r_rdata), .r_busy_out_n(r_busy_out_n)
   );

   task automatic chk(input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic drv_l(input logic ce, input logic rw, input int a, input int d);
      l_ce_n = ce; l_rw_n = rw; l_addr = AW'(a); l_wdata = DW'(d);
   endtask

   task automatic drv_r(input logic ce, input logic rw, input int a, input int d);
      r_ce_n = ce; r_rw_n = rw; r_addr = AW'(a); r_wdata = DW'(d);
   endtask

   // expected outcome of one cycle, computed from the requirements
   task automatic step(input string tag);
      logic en_l, en_r, coll, hl, hr, cont, ll, lr, wl, wr;
      int   win;
      en_l = !l_ce_n;
      en_r = !r_ce_n;
      coll = en_l && en_r && (l_addr == r_addr);
      hl   = m_pen_l && (m_pa_l == l_addr);
      hr   = m_pen_r && (m_pa_r == r_addr);
      cont = (m_owner != 0) && hl && hr;
      win  = cont ? m_owner : ((hr && !hl) ? 2 : 1);
      ll   = coll && (win == 2);
      lr   = coll && (win == 1);
      wl   = en_l && !l_rw_n && (master_mode ? !ll : l_busy_in_n);
      wr   = en_r && !r_rw_n && (master_mode ? !lr : r_busy_in_n);
      if (en_l && l_rw_n) e_rd_l = mem[l_addr];
      if (en_r && r_rw_n) e_rd_r = mem[r_addr];
      e_bl = !(master_mode && ll);
      e_br = !(master_mode && lr);
      if (wr) mem[r_addr] = r_wdata;
      if (wl) mem[l_addr] = l_wdata;
      m_pen_l = en_l; m_pen_r = en_r;
      m_pa_l  = l_addr; m_pa_r = r_addr;
      m_owner = coll ? win : 0;
      @(posedge clk);
      @(negedge clk);
      chk(tag, "l_rdata", l_rdata, e_rd_l);
      chk(tag, "r_rdata", r_rdata, e_rd_r);
      chk(tag, "l_busy_out_n", DW'(l_busy_out_n), DW'(e_bl));
      chk(tag, "r_busy_out_n", DW'(r_busy_out_n), DW'(e_br));
   endtask

   task automatic idle();
      drv_l(1, 1, 0, 0);
      drv_r(1, 1, 0, 0);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd4711);
      for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R9: reset values
      chk("R9", "l_rdata", l_rdata, 8'h00);
      chk("R9", "r_rdata", r_rdata, 8'h00);
      chk("R9", "l_busy_out_n", DW'(l_busy_out_n), 8'h01);
      chk("R9", "r_busy_out_n", DW'(r_busy_out_n), 8'h01);

      // fill a small window of known words
      for (int a = 0; a < 32; a++) begin
         drv_l(0, 0, a, 8'h30 + a); drv_r(1, 1, 0, 0); step("R1");
      end

      // R1: different-address writes both land, cross-port read back
      drv_l(0, 0, 20, 8'hA1); drv_r(0, 0, 21, 8'hB2); step("R1");
      drv_l(0, 1, 21, 0);     drv_r(0, 1, 20, 0);     step("R1");
      // R2: read-before-write on the same word, then hold when not reading
      drv_l(0, 0, 22, 8'h5C); drv_r(0, 1, 22, 0);     step("R2");
      drv_l(1, 1, 0, 0);      drv_r(0, 0, 23, 8'h77); step("R2");
      drv_r(0, 1, 22, 0);                               step("R2");

      // R4: fresh collision, left wins, right write blocked
      idle(); step("R4");
      drv_l(0, 1, 5, 0); drv_r(0, 0, 5, 8'h55); step("R4");
      drv_r(0, 0, 5, 8'h56);                     step("R6");
      drv_r(0, 1, 5, 0);                         step("R6");
      drv_r(1, 1, 5, 0);                         step("R3");
      drv_l(1, 1, 0, 0);                         step("R3");

      // R5: right holds address, left joins and loses
      drv_r(0, 1, 6, 0);                         step("R5");
      drv_l(0, 0, 6, 8'hEE);                     step("R5");
      drv_l(0, 0, 6, 8'hEF);                     step("R6");
      drv_l(0, 1, 6, 0);                         step("R5");
      drv_r(0, 1, 7, 0);                         step("R5");
      drv_r(0, 0, 6, 8'h99);                     step("R5");
      drv_l(0, 1, 6, 0); drv_r(1, 1, 0, 0);      step("R5");

      // R3: two reads collide as well
      idle(); step("R3");
      drv_l(0, 1, 9, 0); drv_r(0, 1, 9, 0);      step("R3");
      step("R3");
      idle(); step("R3");

      // R7: slave mode
      master_mode = 1'b0;
      drv_l(0, 0, 10, 8'h11); drv_r(0, 1, 10, 0); step("R7");
      l_busy_in_n = 1'b0;
      drv_l(0, 0, 11, 8'h12); drv_r(0, 1, 11, 0); step("R7");
      drv_l(0, 1, 11, 0);     drv_r(0, 1, 10, 0); step("R7");
      l_busy_in_n = 1'b1; r_busy_in_n = 1'b0;
      drv_l(0, 1, 12, 0);     drv_r(0, 0, 12, 8'h13); step("R7");
      drv_r(0, 1, 12, 0);                             step("R7");
      r_busy_in_n = 1'b1;
      drv_r(0, 0, 12, 8'h14);                         step("R7");
      // R7: busy_in ignored in master mode
      master_mode = 1'b1; l_busy_in_n = 1'b0; r_busy_in_n = 1'b0;
      idle(); step("R7");
      drv_l(0, 0, 13, 8'h15); drv_r(0, 0, 14, 8'h16); step("R7");
      drv_l(0, 1, 14, 0);     drv_r(0, 1, 13, 0);     step("R7");
      l_busy_in_n = 1'b1; r_busy_in_n = 1'b1;

      // R8: standby writes nothing and holds rdata
      drv_l(1, 0, 15, 8'hF0); drv_r(1, 0, 16, 8'hF1); step("R8");
      drv_l(0, 1, 15, 0);     drv_r(0, 1, 16, 0);     step("R8");

      // random mix
      for (int i = 0; i < 4000; i++) begin
         master_mode = ((i / 400) % 4) != 3;
         l_busy_in_n = ($urandom % 6) != 0;
         r_busy_in_n = ($urandom % 6) != 0;
         drv_l(($urandom % 4) == 0, $urandom % 2, $urandom % 6, $urandom % 256);
         drv_r(($urandom % 4) == 0, $urandom % 2, $urandom % 6, $urandom % 256);
         step(master_mode ? "R3" : "R7");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule